// File: doc/BRIEF.md
# Gated Alternate-Instruction Front-End Filter

This block sits in a byte-wide fetch stream ahead of an ordinary instruction decoder. In normal mode it forwards fetched bytes to the decoder through a one-entry output stage with valid/ready handshaking. It watches the stream for the two-byte entry opcode 0x0F 0x3F. A feature-control register holds the enable for the alternate mode. Only a privileged write can change that register. The whole register can be read back, so software can update it with a read-modify-write and keep the other bits.

When the entry opcode arrives with the enable clear, the block raises an invalid-instruction pulse and stays in normal mode. When the enable is set, the block issues a one-cycle near-branch request to the address on the accumulator input and switches to alternate mode. In that mode every fetched record is a fixed host-instruction wrapper followed by four displacement bytes. The block checks the wrapper, removes it, and presents the 32-bit displacement on a separate payload output. A payload of all ones ends the alternate mode.

Top module: `altmode_frontend`

## Requirements
- R1: After synchronous reset, out_valid, alt_valid, redir_valid, exc_invalid and exc_malformed are 0, alt_mode is 0 and cfg_rd_data reads 0.
- R2: A write with cfg_wr_en=1 and cfg_wr_priv=1 stores all of cfg_wr_data, and cfg_rd_data shows it the next cycle. A write with cfg_wr_priv=0 is ignored and cfg_rd_data is unchanged. Bit 0 is the alternate-mode enable.
- R3: In normal mode, an accepted byte other than 0x0F appears on out_byte with out_valid=1 in the cycle after acceptance. Byte order is preserved, and the output holds steady while out_ready=0.
- R4: In normal mode, a 0x0F followed by any byte other than 0x3F is forwarded as 0x0F and then the following byte is handled normally (a second 0x0F starts a new candidate opcode). A 0x0F is accepted even while the output stage is stalled.
- R5: With the enable at 0, 0x0F 0x3F forwards neither byte, pulses exc_invalid for one cycle in the cycle after 0x3F is accepted, and leaves alt_mode at 0.
- R6: With the enable at 1, 0x0F 0x3F forwards neither byte, pulses redir_valid for one cycle in the cycle after 0x3F is accepted with redir_addr equal to eax_val at acceptance, and sets alt_mode in that same cycle.
- R7: In alternate mode with cs_is16=0, a record is 0x8D 0x84 0x00 d0 d1 d2 d3. alt_insn = {d3,d2,d1,d0} appears with alt_valid=1 in the cycle after d3 is accepted. Wrapper bytes never reach out_byte.
- R8: With cs_is16=1, a record is 0x67 0x8D 0x84 0x00 followed by four payload bytes. cs_is16 is sampled with the first byte of each record.
- R9: A record whose wrapper byte does not match gives exactly one exc_malformed pulse, in the cycle after the first bad byte. The rest of that record's length (7 or 8 bytes) is discarded with no payload output, and the next record is parsed normally.
- R10: A record with payload 0xFFFF_FFFF gives no payload output and returns alt_mode to 0 in the cycle after its last byte. Later bytes pass through as in R3. Any other payload value, including 0xFFFF_FFFE, is output.
- R11: alt_valid and alt_insn hold while alt_ready=0, and in_ready stays 0 in alternate mode until the payload is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Feature-control register write strobe |
| cfg_wr_priv | input | 1 | Write is issued at privileged level |
| cfg_wr_data | input | 8 | Full register value to write |
| cfg_rd_data | output | 8 | Current register value |
| cs_is16 | input | 1 | Code segment is 16-bit (record needs size prefix) |
| eax_val | input | 32 | Branch target for the entry opcode |
| in_valid | input | 1 | Fetched byte valid |
| in_byte | input | 8 | Fetched byte |
| in_ready | output | 1 | Fetched byte accepted this cycle when valid |
| out_valid | output | 1 | Forwarded byte valid |
| out_byte | output | 8 | Forwarded byte to the host decoder |
| out_ready | input | 1 | Decoder takes the forwarded byte |
| alt_valid | output | 1 | Stripped payload valid |
| alt_insn | output | 32 | Stripped 32-bit alternate instruction |
| alt_ready | input | 1 | Consumer takes the payload |
| redir_valid | output | 1 | One-cycle near-branch request |
| redir_addr | output | 32 | Branch target |
| exc_invalid | output | 1 | One-cycle invalid-instruction pulse |
| exc_malformed | output | 1 | One-cycle malformed-record pulse |
| alt_mode | output | 1 | Unit is in alternate mode |

## Verification
Two things can happen in the same cycle: the output stage holding a stalled forwarded byte, and the entry opcode being absorbed and the redirect being issued. The bench provokes this by holding out_ready low behind an ordinary byte and then sending 0x0F 0x3F with the enable set. It checks that the redirect pulse, its address and the mode change appear while the held byte is still on out_byte, unchanged, and that this byte is later delivered alone, with no 0x0F after it. Byte sweeps over all 256 values, with and without a preceding 0x0F, run under a toggling out_ready. Corrupted wrappers are tried at every wrapper position in both segment widths.

// File: rtl/altfe_pkg.sv
package altfe_pkg;

    localparam logic [7:0]  ESC_BYTE    = 8'h0F;
    localparam logic [7:0]  ENTRY_BYTE  = 8'h3F;
    localparam logic [7:0]  PFX16_BYTE  = 8'h67;
    localparam logic [7:0]  WRAP_OP     = 8'h8D;
    localparam logic [7:0]  WRAP_MODRM  = 8'h84;
    localparam logic [7:0]  WRAP_SIB    = 8'h00;
    localparam int          PAYLOAD_W   = 32;
    localparam int          PAYLOAD_B   = PAYLOAD_W / 8;
    localparam int          IDX_W       = 3;
    localparam logic [PAYLOAD_W-1:0] RET_CODE = '1;

    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_ALT    = 1'b1
    } fe_mode_e;

    typedef struct packed {
        logic [IDX_W-1:0]         idx;
        logic                     is16;
        logic                     bad;
        logic [PAYLOAD_W-9:0]     acc;
    } rec_state_t;

    function automatic logic [IDX_W-1:0] wrap_len(input logic is16);
        return is16 ? IDX_W'(4) : IDX_W'(3);
    endfunction

    function automatic logic [7:0] wrap_byte(input logic is16, input logic [IDX_W-1:0] idx);
        logic [7:0] b;
        if (is16) begin
            case (idx)
                3'd0:    b = PFX16_BYTE;
                3'd1:    b = WRAP_OP;
                3'd2:    b = WRAP_MODRM;
                default: b = WRAP_SIB;
            endcase
        end else begin
            case (idx)
                3'd0:    b = WRAP_OP;
                3'd1:    b = WRAP_MODRM;
                default: b = WRAP_SIB;
            endcase
        end
        return b;
    endfunction

endpackage

// File: rtl/altfe_ctrl_reg.sv
module altfe_ctrl_reg #(
    parameter int CFG_W  = 8,
    parameter int EN_BIT = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_priv,
    input  logic [CFG_W-1:0] wr_data,
    output logic [CFG_W-1:0] rd_data,
    output logic             alt_en
);

    logic [CFG_W-1:0] reg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_q <= '0;
        end else if (wr_en && wr_priv) begin
            reg_q <= wr_data;
        end
    end

    assign rd_data = reg_q;
    assign alt_en  = reg_q[EN_BIT];

    assert_unpriv_ignored_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_priv) |=> $stable(rd_data));

    assert_priv_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_priv) |=> (rd_data == $past(wr_data)));

endmodule

// File: rtl/altfe_normal_path.sv
module altfe_normal_path
    import altfe_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              alt_en,
    input  logic [ADDR_W-1:0] eax_val,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    output logic              in_ready,
    output logic              out_valid,
    output logic [7:0]        out_byte,
    input  logic              out_ready,
    output logic              enter_req,
    output logic              redir_valid,
    output logic [ADDR_W-1:0] redir_addr,
    output logic              exc_invalid
);

    logic       pend_q;
    logic       can_load;
    logic       load;
    logic [7:0] load_byte;
    logic       set_pend;
    logic       clr_pend;
    logic       hit;
    logic       inval;

    assign can_load = !out_valid || out_ready;

    always_comb begin
        in_ready  = 1'b0;
        load      = 1'b0;
        load_byte = in_byte;
        set_pend  = 1'b0;
        clr_pend  = 1'b0;
        hit       = 1'b0;
        if (active) begin
            if (pend_q) begin
                if (in_byte == ENTRY_BYTE) begin
                    in_ready = 1'b1;
                    hit      = in_valid;
                    clr_pend = in_valid;
                end else if (in_valid && can_load) begin
                    load      = 1'b1;
                    load_byte = ESC_BYTE;
                    clr_pend  = 1'b1;
                end
            end else if (in_byte == ESC_BYTE) begin
                in_ready = 1'b1;
                set_pend = in_valid;
            end else begin
                in_ready = can_load;
                load     = in_valid && can_load;
            end
        end
    end

    assign enter_req = hit && alt_en;
    assign inval     = hit && !alt_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_byte    <= '0;
            pend_q      <= 1'b0;
            redir_valid <= 1'b0;
            redir_addr  <= '0;
            exc_invalid <= 1'b0;
        end else begin
            if (load) begin
                out_valid <= 1'b1;
                out_byte  <= load_byte;
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end
            if (!active || clr_pend) begin
                pend_q <= 1'b0;
            end else if (set_pend) begin
                pend_q <= 1'b1;
            end
            redir_valid <= enter_req;
            if (enter_req) begin
                redir_addr <= eax_val;
            end
            exc_invalid <= inval;
        end
    end

    assert_out_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));

    assert_exc_excl_R5: assert property (@(posedge clk) disable iff (rst)
        !(redir_valid && exc_invalid));

    assert_exc_needs_clear_en_R5: assert property (@(posedge clk) disable iff (rst)
        exc_invalid |-> !$past(alt_en));

    assert_redir_needs_en_R6: assert property (@(posedge clk) disable iff (rst)
        redir_valid |-> $past(alt_en));

endmodule

// File: rtl/altfe_alt_parser.sv
module altfe_alt_parser
    import altfe_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 active,
    input  logic                 cs_is16,
    input  logic                 in_valid,
    input  logic [7:0]           in_byte,
    output logic                 in_ready,
    output logic                 alt_valid,
    output logic [PAYLOAD_W-1:0] alt_insn,
    input  logic                 alt_ready,
    output logic                 exc_malformed,
    output logic                 exit_req
);

    rec_state_t           st_q;
    logic                 cur16;
    logic [IDX_W-1:0]     wlen;
    logic                 last;
    logic                 in_wrap;
    logic                 mism;
    logic                 bad_eff;
    logic                 take;
    logic                 done_ok;
    logic                 emit;
    logic                 mal;
    logic [PAYLOAD_W-1:0] payload;

    assign cur16    = (st_q.idx == '0) ? cs_is16 : st_q.is16;
    assign wlen     = wrap_len(cur16);
    assign last     = (st_q.idx == (wlen + IDX_W'(PAYLOAD_B - 1)));
    assign in_wrap  = (st_q.idx < wlen);
    assign mism     = in_wrap && (in_byte != wrap_byte(cur16, st_q.idx));
    assign bad_eff  = (st_q.idx == '0) ? 1'b0 : st_q.bad;
    assign in_ready = active && (!alt_valid || alt_ready);
    assign take     = in_valid && in_ready;
    assign payload  = {in_byte, st_q.acc};
    assign mal      = take && mism && !bad_eff;
    assign done_ok  = take && last && !bad_eff;
    assign exit_req = done_ok && (payload == RET_CODE);
    assign emit     = done_ok && (payload != RET_CODE);

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            st_q <= '0;
        end else if (take) begin
            st_q.idx <= last ? '0 : st_q.idx + 1'b1;
            if (st_q.idx == '0) begin
                st_q.is16 <= cs_is16;
            end
            st_q.bad <= bad_eff || mism;
            if (!in_wrap) begin
                st_q.acc <= {in_byte, st_q.acc[PAYLOAD_W-9:8]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            alt_valid     <= 1'b0;
            alt_insn      <= '0;
            exc_malformed <= 1'b0;
        end else begin
            if (emit) begin
                alt_valid <= 1'b1;
                alt_insn  <= payload;
            end else if (alt_ready) begin
                alt_valid <= 1'b0;
            end
            exc_malformed <= mal;
        end
    end

    assert_alt_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (alt_valid && !alt_ready) |=> (alt_valid && $stable(alt_insn)));

    assert_no_ret_out_R10: assert property (@(posedge clk) disable iff (rst)
        alt_valid |-> (alt_insn != RET_CODE));

    assert_mal_single_R9: assert property (@(posedge clk) disable iff (rst)
        exc_malformed |=> !exc_malformed);

    assert_mal_in_alt_R9: assert property (@(posedge clk) disable iff (rst)
        exc_malformed |-> $past(active));

endmodule

// File: rtl/altmode_frontend.sv
module altmode_frontend
    import altfe_pkg::*;
#(
    parameter int CFG_W  = 8,
    parameter int EN_BIT = 0,
    parameter int ADDR_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_wr_en,
    input  logic                 cfg_wr_priv,
    input  logic [CFG_W-1:0]     cfg_wr_data,
    output logic [CFG_W-1:0]     cfg_rd_data,
    input  logic                 cs_is16,
    input  logic [ADDR_W-1:0]    eax_val,
    input  logic                 in_valid,
    input  logic [7:0]           in_byte,
    output logic                 in_ready,
    output logic                 out_valid,
    output logic [7:0]           out_byte,
    input  logic                 out_ready,
    output logic                 alt_valid,
    output logic [PAYLOAD_W-1:0] alt_insn,
    input  logic                 alt_ready,
    output logic                 redir_valid,
    output logic [ADDR_W-1:0]    redir_addr,
    output logic                 exc_invalid,
    output logic                 exc_malformed,
    output logic                 alt_mode
);

    fe_mode_e mode_q;
    logic     alt_en;
    logic     np_ready;
    logic     ap_ready;
    logic     enter_req;
    logic     exit_req;
    logic     is_normal;

    assign is_normal = (mode_q == MODE_NORMAL);

    altfe_ctrl_reg #(
        .CFG_W  (CFG_W),
        .EN_BIT (EN_BIT)
    ) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr_en),
        .wr_priv (cfg_wr_priv),
        .wr_data (cfg_wr_data),
        .rd_data (cfg_rd_data),
        .alt_en  (alt_en)
    );

    altfe_normal_path #(
        .ADDR_W (ADDR_W)
    ) u_norm (
        .clk         (clk),
        .rst         (rst),
        .active      (is_normal),
        .alt_en      (alt_en),
        .eax_val     (eax_val),
        .in_valid    (in_valid),
        .in_byte     (in_byte),
        .in_ready    (np_ready),
        .out_valid   (out_valid),
        .out_byte    (out_byte),
        .out_ready   (out_ready),
        .enter_req   (enter_req),
        .redir_valid (redir_valid),
        .redir_addr  (redir_addr),
        .exc_invalid (exc_invalid)
    );

    altfe_alt_parser u_alt (
        .clk           (clk),
        .rst           (rst),
        .active        (!is_normal),
        .cs_is16       (cs_is16),
        .in_valid      (in_valid),
        .in_byte       (in_byte),
        .in_ready      (ap_ready),
        .alt_valid     (alt_valid),
        .alt_insn      (alt_insn),
        .alt_ready     (alt_ready),
        .exc_malformed (exc_malformed),
        .exit_req      (exit_req)
    );

    assign in_ready = is_normal ? np_ready : ap_ready;
    assign alt_mode = !is_normal;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_NORMAL;
        end else if (enter_req) begin
            mode_q <= MODE_ALT;
        end else if (exit_req) begin
            mode_q <= MODE_NORMAL;
        end
    end

    assert_mode_rise_redir_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(alt_mode) |-> redir_valid);

    assert_no_fwd_in_alt_R7: assert property (@(posedge clk) disable iff (rst)
        (alt_mode && $past(alt_mode) && $past(out_valid && out_ready)) |-> !out_valid);

endmodule

// File: tb/altmode_frontend_tb.sv
module altmode_frontend_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wr_en = 1'b0, cfg_wr_priv = 1'b0;
    logic [7:0]  cfg_wr_data = '0, cfg_rd_data;
    logic        cs_is16 = 1'b0;
    logic [31:0] eax_val = '0;
    logic        in_valid = 1'b0, in_ready;
    logic [7:0]  in_byte = '0;
    logic        out_valid, out_ready;
    logic [7:0]  out_byte;
    logic        alt_valid, alt_ready = 1'b1;
    logic [31:0] alt_insn;
    logic        redir_valid, exc_invalid, exc_malformed, alt_mode;
    logic [31:0] redir_addr;

    int checks = 0, failures = 0;
    int n_inv = 0, n_mal = 0, n_redir = 0;
    logic [7:0]  outq[$], exp_out[$];
    logic [31:0] altq[$], exp_alt[$];
    logic        bp = 1'b0, or_hold = 1'b1;
    int          cyc = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    altmode_frontend u_dut (
        .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_priv(cfg_wr_priv),
        .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data), .cs_is16(cs_is16),
        .eax_val(eax_val), .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
        .out_valid(out_valid), .out_byte(out_byte), .out_ready(out_ready),
        .alt_valid(alt_valid), .alt_insn(alt_insn), .alt_ready(alt_ready),
        .redir_valid(redir_valid), .redir_addr(redir_addr), .exc_invalid(exc_invalid),
        .exc_malformed(exc_malformed), .alt_mode(alt_mode)
    );

    always @(negedge clk) begin
        cyc = cyc + 1;
        out_ready = bp ? (cyc[0] ^ cyc[2]) : or_hold;
    end

    always begin
        @(negedge clk); #1;
        if (out_valid && out_ready) outq.push_back(out_byte);
        if (alt_valid && alt_ready) altq.push_back(alt_insn);
        if (exc_invalid) n_inv++;
        if (exc_malformed) n_mal++;
        if (redir_valid) n_redir++;
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic clear_obs();
        outq.delete(); altq.delete(); exp_out.delete(); exp_alt.delete();
        n_inv = 0; n_mal = 0; n_redir = 0;
    endtask

    task automatic cmp_out(input string tag);
        bit ok = (outq.size() == exp_out.size());
        int bad_i = -1;
        if (ok) foreach (exp_out[i]) if (bad_i < 0 && outq[i] !== exp_out[i]) bad_i = i;
        if (!ok) chk(0, {tag, " out count"}, outq.size(), exp_out.size());
        else if (bad_i >= 0) chk(0, {tag, " out byte"}, outq[bad_i], exp_out[bad_i]);
        else chk(1, tag, 0, 0);
    endtask

    task automatic cmp_alt(input string tag);
        bit ok = (altq.size() == exp_alt.size());
        int bad_i = -1;
        if (ok) foreach (exp_alt[i]) if (bad_i < 0 && altq[i] !== exp_alt[i]) bad_i = i;
        if (!ok) chk(0, {tag, " alt count"}, altq.size(), exp_alt.size());
        else if (bad_i >= 0) chk(0, {tag, " alt word"}, altq[bad_i], exp_alt[bad_i]);
        else chk(1, tag, 0, 0);
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk); in_valid = 1'b1; in_byte = b; #1;
        while (!in_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic cfg_write(input logic [7:0] d, input logic priv);
        @(negedge clk); cfg_wr_en = 1'b1; cfg_wr_data = d; cfg_wr_priv = priv;
        @(negedge clk); cfg_wr_en = 1'b0; cfg_wr_priv = 1'b0; #1;
    endtask

    task automatic send_rec(input logic is16, input logic [31:0] p, input int bad_pos);
        logic [7:0] w[8];
        int n;
        n = is16 ? 8 : 7;
        if (is16) begin w[0] = 8'h67; w[1] = 8'h8D; w[2] = 8'h84; w[3] = 8'h00; end
        else begin w[0] = 8'h8D; w[1] = 8'h84; w[2] = 8'h00; end
        for (int k = 0; k < 4; k++) w[n-4+k] = p[8*k +: 8];
        if (bad_pos >= 0) w[bad_pos] = w[bad_pos] ^ 8'h5A;
        for (int k = 0; k < n; k++) send(w[k]);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        finish_up();
    end

    initial begin
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk(!out_valid && !alt_valid && !redir_valid && !exc_invalid && !exc_malformed && !alt_mode,
            "R1 reset outputs", {out_valid, alt_valid, redir_valid, exc_invalid, exc_malformed, alt_mode}, 0);
        chk(cfg_rd_data == 8'h00, "R1 cfg reset", cfg_rd_data, 0);
        clear_obs();

        // R2 privileged write, unprivileged ignored
        cfg_write(8'hA4, 1'b1);
        chk(cfg_rd_data == 8'hA4, "R2 priv write", cfg_rd_data, 8'hA4);
        cfg_write(8'h5B, 1'b0);
        chk(cfg_rd_data == 8'hA4, "R2 unpriv ignored", cfg_rd_data, 8'hA4);

        // R3 latency
        send(8'h55);
        @(negedge clk); #1;
        chk(out_valid && out_byte == 8'h55, "R3 one-cycle latency", {out_valid, out_byte}, {1'b1, 8'h55});
        idle(3);
        clear_obs();

        // R3 full sweep under backpressure
        bp = 1'b1;
        for (int v = 0; v < 256; v++) begin
            if (v != 15) begin send(8'(v)); exp_out.push_back(8'(v)); end
        end
        idle(8);
        cmp_out("R3 sweep");

        // R4 escape followed by every non-entry byte
        clear_obs();
        for (int v = 0; v < 256; v++) begin
            if (v != 8'h3F) begin
                send(8'h0F); send(8'(v)); send(8'h22);
                exp_out.push_back(8'h0F); exp_out.push_back(8'(v)); exp_out.push_back(8'h22);
            end
        end
        idle(8);
        bp = 1'b0;
        idle(2);
        cmp_out("R4 escape sweep");
        chk(n_inv == 0 && n_redir == 0, "R4 no exception", n_inv + n_redir, 0);

        // R5 entry opcode with enable clear
        clear_obs();
        send(8'h0F); send(8'h3F);
        @(negedge clk); #1;
        chk(exc_invalid && !redir_valid && !alt_mode, "R5 invalid pulse", {exc_invalid, redir_valid, alt_mode}, 3'b100);
        @(negedge clk); #1;
        chk(!exc_invalid, "R5 pulse one cycle", exc_invalid, 0);
        send(8'h44); exp_out.push_back(8'h44);
        idle(4);
        cmp_out("R5 opcode not forwarded");
        chk(n_inv == 1, "R5 pulse count", n_inv, 1);

        // R2 read-modify-write of the enable, preserving other bits
        cfg_write(cfg_rd_data | 8'h01, 1'b1);
        chk(cfg_rd_data == 8'hA5, "R2 rmw keeps bits", cfg_rd_data, 8'hA5);

        // R6 entry while the output stage holds a stalled byte
        clear_obs();
        eax_val = 32'h1234_5678;
        or_hold = 1'b0;
        send(8'h41); send(8'h0F); send(8'h3F);
        eax_val = 32'hDEAD_0000;
        @(negedge clk); #1;
        chk(redir_valid && redir_addr == 32'h1234_5678, "R6 redirect", redir_addr, 32'h1234_5678);
        chk(alt_mode && !exc_invalid, "R6 mode set", {alt_mode, exc_invalid}, 2'b10);
        chk(out_valid && out_byte == 8'h41, "R3 held byte during entry", out_byte, 8'h41);
        @(negedge clk); #1;
        chk(!redir_valid, "R6 pulse one cycle", redir_valid, 0);
        or_hold = 1'b1;
        exp_out.push_back(8'h41);
        idle(4);
        cmp_out("R4 held byte alone");

        // R7 32-bit records
        clear_obs();
        cs_is16 = 1'b0;
        send_rec(1'b0, 32'hCAFE_F00D, -1);
        @(negedge clk); #1;
        chk(alt_valid && alt_insn == 32'hCAFE_F00D, "R7 payload latency", alt_insn, 32'hCAFE_F00D);
        exp_alt.push_back(32'hCAFE_F00D);
        for (int i = 0; i < 24; i++) begin
            logic [31:0] p = (32'(i) * 32'h0101_0101) ^ (32'h8000_0001 << (i % 31));
            send_rec(1'b0, p, -1); exp_alt.push_back(p);
        end
        idle(3);
        cmp_alt("R7 payload sweep");
        cmp_out("R7 nothing forwarded");

        // R9 malformed at each wrapper position
        clear_obs();
        for (int k = 0; k < 3; k++) begin
            send_rec(1'b0, 32'h1111_0000 + 32'(k), k);
            send_rec(1'b0, 32'h2222_0000 + 32'(k), -1);
            exp_alt.push_back(32'h2222_0000 + 32'(k));
        end
        send_rec(1'b0, 32'h3333_3333, 0);
        idle(3);
        chk(n_mal == 4, "R9 one pulse per bad record", n_mal, 4);
        cmp_alt("R9 bad record discarded");

        // R8 16-bit records, with malformed at each wrapper position
        clear_obs();
        cs_is16 = 1'b1;
        send_rec(1'b1, 32'h0BAD_BEEF, -1); exp_alt.push_back(32'h0BAD_BEEF);
        for (int k = 0; k < 4; k++) begin
            send_rec(1'b1, 32'h4444_0000 + 32'(k), k);
            send_rec(1'b1, 32'h5555_0000 + 32'(k), -1);
            exp_alt.push_back(32'h5555_0000 + 32'(k));
        end
        send_rec(1'b0, 32'h6666_6666, -1);
        send(8'h00);
        send_rec(1'b1, 32'h7777_7777, -1); exp_alt.push_back(32'h7777_7777);
        idle(3);
        chk(n_mal == 5, "R8 prefix required", n_mal, 5);
        cmp_alt("R8 16-bit payloads");

        // R8 width sampled at record start
        clear_obs();
        cs_is16 = 1'b0;
        send(8'h8D);
        cs_is16 = 1'b1;
        send(8'h84); send(8'h00); send(8'h01); send(8'h02); send(8'h03); send(8'h04);
        idle(3);
        exp_alt.push_back(32'h0403_0201);
        cmp_alt("R8 width sampled at start");
        chk(n_mal == 0, "R8 no error on width change", n_mal, 0);
        cs_is16 = 1'b0;

        // R11 payload held under backpressure
        clear_obs();
        alt_ready = 1'b0;
        send_rec(1'b0, 32'hABCD_0123, -1);
        @(negedge clk); in_valid = 1'b1; in_byte = 8'h8D;
        for (int c = 0; c < 3; c++) begin
            #1;
            chk(!in_ready && alt_valid && alt_insn == 32'hABCD_0123, "R11 hold and stall",
                {in_ready, alt_valid, alt_insn}, {1'b0, 1'b1, 32'hABCD_0123});
            @(negedge clk);
        end
        alt_ready = 1'b1;
        @(posedge clk); #1; in_valid = 1'b0;
        send(8'h84); send(8'h00);
        send(8'h10); send(8'h20); send(8'h30); send(8'h40);
        idle(3);
        exp_alt.push_back(32'hABCD_0123); exp_alt.push_back(32'h4030_2010);
        cmp_alt("R11 order after stall");

        // R10 near-return value is output, return value leaves mode
        clear_obs();
        send_rec(1'b0, 32'hFFFF_FFFE, -1); exp_alt.push_back(32'hFFFF_FFFE);
        send_rec(1'b0, 32'hFFFF_FFFF, -1);
        @(negedge clk); #1;
        chk(!alt_mode, "R10 mode cleared", alt_mode, 0);
        chk(!alt_valid, "R10 no payload for return", alt_valid, 0);
        send(8'h77); exp_out.push_back(8'h77);
        send(8'h8D); exp_out.push_back(8'h8D);
        idle(4);
        cmp_alt("R10 payloads");
        cmp_out("R10 passthrough after return");

        finish_up();
    end

endmodule